// File: doc/BRIEF.md
# Temperature to fan duty mapper

This block turns a measured control temperature into a target duty for a cooling fan's PWM generator. The temperature is an 8-bit two's-complement value in whole degrees Celsius. The block follows a piecewise-linear curve with four regions:

- **Stop:** the fan is stopped at or below a passive-cooling threshold.
- **Floor:** the fan runs at a programmed minimum duty up to a low temperature.
- **Ramp:** above the low temperature, the duty climbs by a fixed amount per degree.
- **Full:** once the climb reaches the top of the scale, the duty is held at 100%.

Two tach monitoring flags can enable a final cutoff stage. When that stage is active, it drops very small duties to zero so that the fan is never driven too slowly to spin.

A new target is computed each time the temperature-valid input is asserted. The result is registered, and a valid strobe accompanies it one cycle later. A two-state sequencer produces the strobe:

- `ST_HOLD` moves to `ST_SHOW` when `temp_vld` is high.
- `ST_SHOW` stays in `ST_SHOW` while `temp_vld` is high.
- `ST_SHOW` returns to `ST_HOLD` when `temp_vld` is low.

The output `duty_vld` is high exactly while the state is `ST_SHOW`. Between samples, the last target is held. Temperature sensing, PWM waveform generation and register access are outside this block.

Top module: `fan_curve_mapper`

## Requirements
- R1: When the temperature is above the passive threshold and at or below the low temperature, the target equals `duty_low`.
- R2: The high temperature is the low temperature plus ceil((255 - `duty_low`) / increment). At or above it (and above the passive threshold), the target is 255. One degree below it, the target is below 255.
- R3: Between the low and high temperatures, the target is `duty_low` + (temperature - low temperature) × increment. The increment is 1, 2, 4, 8, 16 or 32 for `slope_code` 0 to 5, and 32 for codes 6 and 7.
- R4: The low temperature is 4 × `low_code` °C, with `low_code` unsigned (0 to 124 °C).
- R5: When the temperature is at or below `psv_temp` (signed comparison), the target is 0, even inside the floor region.
- R6: With `tach_en`=1 and `tach_mode`=0, a computed target below 18 becomes 0. Targets of 18 and above pass unchanged.
- R7: With any other combination of `tach_en` and `tach_mode`, the computed target is output unchanged, even below 18.
- R8: After reset, `duty_out` is 84 and `duty_vld` is 0.
- R9: `duty_vld` is high in the cycle after each cycle in which `temp_vld` is high, and low otherwise.
- R10: Without `temp_vld`, `duty_out` holds its value whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| temp_vld | input | 1 | Temperature sample valid; triggers a recompute |
| temp_c | input | 8 | Control temperature, signed, °C |
| low_code | input | 5 | Low-temperature code (4 °C per step) |
| slope_code | input | 3 | Duty increment per °C, as a power of two |
| duty_low | input | 8 | Duty on the minimum-speed floor |
| psv_temp | input | 8 | Passive-cooling threshold, signed, °C |
| tach_en | input | 1 | Tach monitoring enabled |
| tach_mode | input | 1 | Tach mode; 0 enables the low-duty cutoff when `tach_en` is 1 |
| duty_out | output | 8 | Registered target duty, 255 = 100% |
| duty_vld | output | 1 | Target updated in the previous cycle |

## Verification
The curve is tested with temperatures on each side of every region boundary:

- **Floor/ramp boundary:** samples at the low temperature and one degree above it.
- **Full-scale boundary:** samples one degree below the ceiling-derived high temperature and exactly at it, so that a floor-divided boundary would be caught.
- **Passive threshold:** samples at it and one degree above it, including negative values, so that an unsigned comparison would be caught.

Every slope code is applied, including 6 and 7, so that a missing clamp is exposed. The extremes of the low-temperature code are also covered.

The cutoff is tested with targets of 17 and 18, both on the floor and on the ramp, under all four flag combinations. This separates the single cutting combination from the others and also checks the inclusive edge of the cutoff.

// File: rtl/fcm_pkg.sv
package fcm_pkg;
    typedef enum logic [1:0] {
        RG_STOP,
        RG_FLOOR,
        RG_RAMP,
        RG_FULL
    } region_e;

    typedef enum logic {
        ST_HOLD,
        ST_SHOW
    } state_e;
endpackage

// File: rtl/fcm_ramp.sv
module fcm_ramp #(
    parameter int EXT_W     = 10,
    parameter int DUTY_W    = 8,
    parameter int SLOPE_W   = 3,
    parameter int MAX_SHIFT = 5
) (
    input  logic signed [EXT_W-1:0]   t_x,
    input  logic signed [EXT_W-1:0]   l_x,
    input  logic        [SLOPE_W-1:0] slope_code,
    input  logic        [DUTY_W-1:0]  duty_low,
    output logic        [DUTY_W-1:0]  ramp_duty,
    output logic                      ramp_over
);
    localparam int PROD_W = EXT_W + MAX_SHIFT + 2;
    localparam logic [SLOPE_W-1:0] MAX_SH_C = SLOPE_W'(MAX_SHIFT);

    logic        [SLOPE_W-1:0] shift_amt;
    logic signed [EXT_W-1:0]   diff;
    logic        [PROD_W-1:0]  diff_u;
    logic        [PROD_W-1:0]  prod;
    logic        [PROD_W-1:0]  sum;

    always_comb begin
        shift_amt = (slope_code > MAX_SH_C) ? MAX_SH_C : slope_code;
        diff      = t_x - l_x;
        diff_u    = diff[EXT_W-1] ? '0 : {{(PROD_W-EXT_W){1'b0}}, diff};
        prod      = diff_u << shift_amt;
        sum       = {{(PROD_W-DUTY_W){1'b0}}, duty_low} + prod;
        ramp_over = |sum[PROD_W-1:DUTY_W];
        ramp_duty = ramp_over ? '1 : sum[DUTY_W-1:0];
    end
endmodule

// File: rtl/fcm_region.sv
module fcm_region
    import fcm_pkg::*;
#(
    parameter int EXT_W = 10
) (
    input  logic signed [EXT_W-1:0] t_x,
    input  logic signed [EXT_W-1:0] p_x,
    input  logic signed [EXT_W-1:0] l_x,
    input  logic                    ramp_over,
    output region_e                 region
);
    always_comb begin
        if (t_x <= p_x)
            region = RG_STOP;
        else if (t_x <= l_x)
            region = RG_FLOOR;
        else if (ramp_over)
            region = RG_FULL;
        else
            region = RG_RAMP;
    end
endmodule

// File: rtl/fcm_cutoff.sv
module fcm_cutoff #(
    parameter int DUTY_W = 8,
    parameter int CUTOFF = 18
) (
    input  logic [DUTY_W-1:0] duty_in,
    input  logic              tach_en,
    input  logic              tach_mode,
    output logic [DUTY_W-1:0] duty_out
);
    localparam logic [DUTY_W-1:0] CUT_C = DUTY_W'(CUTOFF);

    logic cut_active;

    always_comb begin
        cut_active = tach_en && !tach_mode;
        duty_out   = (cut_active && (duty_in < CUT_C)) ? '0 : duty_in;
    end
endmodule

// File: rtl/fan_curve_mapper.sv
module fan_curve_mapper
    import fcm_pkg::*;
#(
    parameter int TEMP_W    = 8,
    parameter int DUTY_W    = 8,
    parameter int LOWC_W    = 5,
    parameter int LOW_SHIFT = 2,
    parameter int SLOPE_W   = 3,
    parameter int MAX_SHIFT = 5,
    parameter int CUTOFF    = 18,
    parameter int DUTY_RST  = 84
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              temp_vld,
    input  logic [TEMP_W-1:0] temp_c,
    input  logic [LOWC_W-1:0] low_code,
    input  logic [SLOPE_W-1:0] slope_code,
    input  logic [DUTY_W-1:0] duty_low,
    input  logic [TEMP_W-1:0] psv_temp,
    input  logic              tach_en,
    input  logic              tach_mode,
    output logic [DUTY_W-1:0] duty_out,
    output logic              duty_vld
);
    localparam int LT_W  = LOWC_W + LOW_SHIFT;
    localparam int EXT_W = ((TEMP_W > LT_W) ? TEMP_W : LT_W) + 2;

    logic signed [EXT_W-1:0] t_x;
    logic signed [EXT_W-1:0] p_x;
    logic signed [EXT_W-1:0] l_x;
    logic [DUTY_W-1:0] ramp_duty;
    logic              ramp_over;
    region_e           region;
    logic [DUTY_W-1:0] curve_duty;
    logic [DUTY_W-1:0] final_duty;
    state_e            state_q;
    state_e            state_d;
    logic [DUTY_W-1:0] duty_q;

    always_comb begin
        t_x = {{(EXT_W-TEMP_W){temp_c[TEMP_W-1]}}, temp_c};
        p_x = {{(EXT_W-TEMP_W){psv_temp[TEMP_W-1]}}, psv_temp};
        l_x = {{(EXT_W-LT_W){1'b0}}, low_code, {LOW_SHIFT{1'b0}}};
    end

    fcm_ramp #(
        .EXT_W    (EXT_W),
        .DUTY_W   (DUTY_W),
        .SLOPE_W  (SLOPE_W),
        .MAX_SHIFT(MAX_SHIFT)
    ) ramp_i (
        .t_x       (t_x),
        .l_x       (l_x),
        .slope_code(slope_code),
        .duty_low  (duty_low),
        .ramp_duty (ramp_duty),
        .ramp_over (ramp_over)
    );

    fcm_region #(
        .EXT_W(EXT_W)
    ) region_i (
        .t_x      (t_x),
        .p_x      (p_x),
        .l_x      (l_x),
        .ramp_over(ramp_over),
        .region   (region)
    );

    always_comb begin
        unique case (region)
            RG_STOP:  curve_duty = '0;
            RG_FLOOR: curve_duty = duty_low;
            RG_RAMP:  curve_duty = ramp_duty;
            RG_FULL:  curve_duty = '1;
            default:  curve_duty = '0;
        endcase
    end

    fcm_cutoff #(
        .DUTY_W(DUTY_W),
        .CUTOFF(CUTOFF)
    ) cutoff_i (
        .duty_in  (curve_duty),
        .tach_en  (tach_en),
        .tach_mode(tach_mode),
        .duty_out (final_duty)
    );

    // next-state logic
    always_comb begin
        unique case (state_q)
            ST_HOLD: state_d = temp_vld ? ST_SHOW : ST_HOLD;
            ST_SHOW: state_d = temp_vld ? ST_SHOW : ST_HOLD;
            default: state_d = ST_HOLD;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_HOLD;
        else
            state_q <= state_d;
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            duty_q <= DUTY_W'(DUTY_RST);
        else if (temp_vld)
            duty_q <= final_duty;
    end

    assign duty_out = duty_q;
    assign duty_vld = (state_q == ST_SHOW);
endmodule

// File: rtl/fcm_checker.sv
module fcm_checker #(
    parameter int TEMP_W = 8,
    parameter int DUTY_W = 8,
    parameter int CUTOFF = 18
) (
    input logic              clk,
    input logic              rst_n,
    input logic              temp_vld,
    input logic [TEMP_W-1:0] temp_c,
    input logic [TEMP_W-1:0] psv_temp,
    input logic              tach_en,
    input logic              tach_mode,
    input logic [DUTY_W-1:0] duty_out,
    input logic              duty_vld
);
    a_r9_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        temp_vld |=> duty_vld);

    a_r9_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !temp_vld |=> !duty_vld);

    a_r10_hold_without_sample: assert property (@(posedge clk) disable iff (!rst_n)
        !temp_vld |=> $stable(duty_out));

    a_r5_passive_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (temp_vld && ($signed(temp_c) <= $signed(psv_temp))) |=> (duty_out == '0));

    a_r6_cutoff_floor: assert property (@(posedge clk) disable iff (!rst_n)
        (temp_vld && tach_en && !tach_mode)
            |=> ((duty_out == '0) || (duty_out >= DUTY_W'(CUTOFF))));
endmodule

bind fan_curve_mapper fcm_checker #(
    .TEMP_W(TEMP_W),
    .DUTY_W(DUTY_W),
    .CUTOFF(CUTOFF)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .temp_vld (temp_vld),
    .temp_c   (temp_c),
    .psv_temp (psv_temp),
    .tach_en  (tach_en),
    .tach_mode(tach_mode),
    .duty_out (duty_out),
    .duty_vld (duty_vld)
);

// File: tb/fan_curve_mapper_tb_top.sv
module fan_curve_mapper_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 5000;

    typedef struct packed {
        logic [7:0] t;
        logic [4:0] lc;
        logic [2:0] sl;
        logic [7:0] dl;
        logic [7:0] pv;
        logic       en;
        logic       md;
        logic [7:0] ex;
        logic [3:0] rq;
    } vec_t;

    localparam int NV = 28;
    localparam vec_t VECS [NV] = '{
        '{8'd30,  5'd10, 3'd2, 8'd84, 8'hD8, 1'b0, 1'b0, 8'd84,  4'd1}, // R1 below low
        '{8'd40,  5'd10, 3'd2, 8'd84, 8'hD8, 1'b0, 1'b0, 8'd84,  4'd1}, // R1 at low
        '{8'd41,  5'd10, 3'd2, 8'd84, 8'hD8, 1'b0, 1'b0, 8'd88,  4'd3}, // R3 one above
        '{8'd50,  5'd10, 3'd2, 8'd84, 8'hD8, 1'b0, 1'b0, 8'd124, 4'd3}, // R3
        '{8'd45,  5'd10, 3'd5, 8'd84, 8'hD8, 1'b0, 1'b0, 8'd244, 4'd3}, // R3 x32
        '{8'd45,  5'd10, 3'd7, 8'd84, 8'hD8, 1'b0, 1'b0, 8'd244, 4'd3}, // R3 code 7
        '{8'd46,  5'd10, 3'd6, 8'd84, 8'hD8, 1'b0, 1'b0, 8'd255, 4'd2}, // R2 code 6
        '{8'd127, 5'd10, 3'd0, 8'd84, 8'hD8, 1'b0, 1'b0, 8'd171, 4'd3}, // R3 x1
        '{8'd61,  5'd10, 3'd3, 8'd84, 8'hD8, 1'b0, 1'b0, 8'd252, 4'd2}, // R2 high-1
        '{8'd62,  5'd10, 3'd3, 8'd84, 8'hD8, 1'b0, 1'b0, 8'd255, 4'd2}, // R2 at high
        '{8'd42,  5'd10, 3'd4, 8'd84, 8'hD8, 1'b0, 1'b0, 8'd116, 4'd3}, // R3 x16
        '{8'd5,   5'd0,  3'd0, 8'd84, 8'hD8, 1'b0, 1'b0, 8'd89,  4'd4}, // R4 code 0
        '{8'd124, 5'd31, 3'd1, 8'd84, 8'hD8, 1'b0, 1'b0, 8'd84,  4'd4}, // R4 code 31
        '{8'd125, 5'd31, 3'd1, 8'd84, 8'hD8, 1'b0, 1'b0, 8'd86,  4'd4}, // R4 code 31
        '{8'd50,  5'd10, 3'd2, 8'd84, 8'd50, 1'b0, 1'b0, 8'd0,   4'd5}, // R5 at psv
        '{8'd51,  5'd10, 3'd2, 8'd84, 8'd50, 1'b0, 1'b0, 8'd128, 4'd5}, // R5 above psv
        '{8'd30,  5'd10, 3'd2, 8'd84, 8'd50, 1'b0, 1'b0, 8'd0,   4'd5}, // R5 overrides floor
        '{8'hD8,  5'd10, 3'd2, 8'd84, 8'hD8, 1'b0, 1'b0, 8'd0,   4'd5}, // R5 -40
        '{8'hD9,  5'd10, 3'd2, 8'd84, 8'hD8, 1'b0, 1'b0, 8'd84,  4'd1}, // R1 -39
        '{8'd30,  5'd10, 3'd2, 8'd17, 8'hD8, 1'b1, 1'b0, 8'd0,   4'd6}, // R6 floor 17
        '{8'd30,  5'd10, 3'd2, 8'd18, 8'hD8, 1'b1, 1'b0, 8'd18,  4'd6}, // R6 floor 18
        '{8'd47,  5'd10, 3'd0, 8'd10, 8'hD8, 1'b1, 1'b0, 8'd0,   4'd6}, // R6 ramp 17
        '{8'd48,  5'd10, 3'd0, 8'd10, 8'hD8, 1'b1, 1'b0, 8'd18,  4'd6}, // R6 ramp 18
        '{8'd50,  5'd10, 3'd2, 8'd84, 8'hD8, 1'b1, 1'b0, 8'd124, 4'd6}, // R6 high duty
        '{8'd30,  5'd10, 3'd2, 8'd17, 8'hD8, 1'b1, 1'b1, 8'd17,  4'd7}, // R7 en mode1
        '{8'd30,  5'd10, 3'd2, 8'd17, 8'hD8, 1'b0, 1'b0, 8'd17,  4'd7}, // R7 off
        '{8'd30,  5'd10, 3'd2, 8'd17, 8'hD8, 1'b0, 1'b1, 8'd17,  4'd7}, // R7 off mode1
        '{8'd47,  5'd10, 3'd0, 8'd10, 8'hD8, 1'b0, 1'b1, 8'd17,  4'd7}  // R7 ramp 17
    };

    logic       clk;
    logic       rst_n;
    logic       temp_vld;
    logic [7:0] temp_c;
    logic [4:0] low_code;
    logic [2:0] slope_code;
    logic [7:0] duty_low;
    logic [7:0] psv_temp;
    logic       tach_en;
    logic       tach_mode;
    logic [7:0] duty_out;
    logic       duty_vld;

    int n_checks;
    int n_fail;
    int cycles;
    bit done;

    fan_curve_mapper dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .temp_vld  (temp_vld),
        .temp_c    (temp_c),
        .low_code  (low_code),
        .slope_code(slope_code),
        .duty_low  (duty_low),
        .psv_temp  (psv_temp),
        .tach_en   (tach_en),
        .tach_mode (tach_mode),
        .duty_out  (duty_out),
        .duty_vld  (duty_vld)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic load(input vec_t v);
        temp_c     = v.t;
        low_code   = v.lc;
        slope_code = v.sl;
        duty_low   = v.dl;
        psv_temp   = v.pv;
        tach_en    = v.en;
        tach_mode  = v.md;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        cycles = 0;
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > WATCHDOG) begin
                n_checks++;
                n_fail++;
                $display("FAIL watchdog: actual %0d expected %0d", cycles, WATCHDOG);
                finish_run();
            end
        end
    end

    initial begin
        n_checks = 0;
        n_fail   = 0;
        done     = 1'b0;
        rst_n    = 1'b0;
        temp_vld = 1'b0;
        load(VECS[0]);
        repeat (3) @(negedge clk);
        // R8 reset state
        check("R8 duty after reset", duty_out, 84);
        check("R8 valid after reset", duty_vld, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R8 duty held after release", duty_out, 84);

        // table walk
        for (int i = 0; i < NV; i++) begin
            load(VECS[i]);
            temp_vld = 1'b1;
            @(negedge clk);
            temp_vld = 1'b0;
            check($sformatf("R%0d vector %0d", VECS[i].rq, i), duty_out, VECS[i].ex);
            check("R9 valid after sample", duty_vld, 1);
            @(negedge clk);
            check("R9 valid drops", duty_vld, 0);
        end

        // R10: inputs move without temp_vld
        load(VECS[3]);
        repeat (3) @(negedge clk);
        check("R10 duty held", duty_out, 17);
        check("R10 valid stays low", duty_vld, 0);

        // R9 back-to-back samples
        load(VECS[3]);
        temp_vld = 1'b1;
        @(negedge clk);
        check("R9 first of pair duty", duty_out, 124);
        check("R9 first of pair valid", duty_vld, 1);
        load(VECS[9]);
        @(negedge clk);
        temp_vld = 1'b0;
        check("R9 second of pair duty", duty_out, 255);
        check("R9 second of pair valid", duty_vld, 1);
        @(negedge clk);
        check("R9 valid after pair", duty_vld, 0);

        // R8 reset mid-run
        rst_n = 1'b0;
        @(negedge clk);
        check("R8 duty after mid reset", duty_out, 84);
        check("R8 valid after mid reset", duty_vld, 0);
        rst_n = 1'b1;
        @(negedge clk);
        finish_run();
    end
endmodule